// File: doc/BRIEF.md
# SD Card SPI-Mode Command Framer

This block issues one SPI-mode card command and returns the card's one-byte status reply. The user supplies a 6-bit command index, a 32-bit argument and a one-cycle start pulse. The block first clocks out idle bytes until the card stops signalling busy. It then shifts out a 6-byte command frame. After that it clocks idle bytes until a reply byte arrives whose most significant bit is low.

A built-in byte shifter drives the serial clock and data-out lines and samples data-in. Each byte is sent most significant bit first, in mode 0. When the command reads the operating-conditions register and the card accepts it, the four bytes that follow are gathered into a wide result field. The caller controls chip select and moves any data blocks itself. The block raises `done` for one cycle when the reply and the extra field are valid.

Top module: `sdspi_cmd_framer`

## Requirements
- R1: The first frame byte has bits 7:6 equal to 2'b01 and bits 5:0 equal to the command index (0x40 | index).
- R2: Frame bytes 2 to 5 carry the argument, most significant byte first.
- R3: The sixth frame byte is always 0x95, whatever the command.
- R4: Before the frame, one received byte is discarded. Idle bytes (0xFF out) are then clocked until the card returns 0xFF, and only then does the frame start.
- R5: If the card has not returned 0xFF within READY_WAIT_CYCLES clock cycles of the start, no frame is sent. `resp` is 0xFF, `extra` is 0 and `done` pulses.
- R6: For command index 12 only, one extra received byte is discarded between the frame and the reply poll.
- R7: Reply polling stops at the first byte with bit 7 clear, or after POLL_LIMIT (10) bytes. `resp` is the last byte received, even when its bit 7 is still set.
- R8: For command index 58 with a reply of 0x00, the next four bytes are captured into `extra`, the first received byte landing in bits 31:24. In every other case `extra` is 0 after the command.
- R9: `busy` rises the cycle after an accepted start. `done` is a single-cycle pulse while `busy` is high, and `busy` is low the cycle after `done`.
- R10: A start pulse while `busy` is high is ignored: the running command completes unchanged and `done` pulses only once.
- R11: The serial clock idles low and data-out idles high. Every byte clocked while not in the frame carries 0xFF.
- R12: `resp` and `extra` reset to 0xFF and 0 and hold their values between commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to issue a command |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| resp | output | 8 | Status reply byte |
| extra | output | 32 | Trailing register bytes (command 58) |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |

## Verification
`busy` is due one cycle after the start edge, so the bench samples it on the falling edge that follows. `resp` and `extra` are due in the cycle where `done` is high, which comes one cycle after the last byte transfer ends; the bench waits for `done` on falling edges and reads both outputs there. Every serial byte is complete when its eighth rising clock edge occurs, so the bench's card model logs each outgoing byte at that edge. Byte positions and counts are then compared once `done` has been seen.

// File: rtl/sdspi_cmd_pkg.sv
package sdspi_cmd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FLUSH,
      ST_READY,
      ST_SEND,
      ST_STUFF,
      ST_RESP,
      ST_OCR,
      ST_FIN
   } fr_state_t;

   localparam logic [1:0] START_PREFIX = 2'b01;
   localparam logic [7:0] IDLE_BYTE    = 8'hFF;
   localparam logic [5:0] IDX_STOP     = 6'd12;
   localparam logic [5:0] IDX_READ_OCR = 6'd58;
   localparam int         ARG_BYTES    = 4;
   localparam int         FRAME_BYTES  = ARG_BYTES + 2;
   localparam int         FIDX_W       = 3;

endpackage

// File: rtl/sdspi_byte_xfer.sv
module sdspi_byte_xfer #(
   parameter int CLK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx_byte,
   output logic       xdone,
   output logic [7:0] rx_byte,
   output logic       sclk,
   output logic       mosi,
   input  logic       miso
);

   logic       active;
   logic       tick;
   logic [7:0] sh_tx;
   logic [7:0] sh_rx;
   logic [2:0] bitn;

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = active;
      end else begin : g_div
         localparam int DW = $clog2(CLK_DIV);
         logic [DW-1:0] div_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_cnt <= '0;
            end else if (!active) begin
               div_cnt <= '0;
            end else if (div_cnt == DW'(CLK_DIV - 1)) begin
               div_cnt <= '0;
            end else begin
               div_cnt <= div_cnt + 1'b1;
            end
         end
         assign tick = active && (div_cnt == DW'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sh_tx  <= 8'hFF;
         sh_rx  <= 8'h00;
         bitn   <= 3'd0;
         sclk   <= 1'b0;
         xdone  <= 1'b0;
      end else begin
         xdone <= 1'b0;
         if (!active) begin
            if (go) begin
               active <= 1'b1;
               sh_tx  <= tx_byte;
               bitn   <= 3'd0;
               sclk   <= 1'b0;
            end
         end else if (tick) begin
            if (!sclk) begin
               sclk  <= 1'b1;
               sh_rx <= {sh_rx[6:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bitn == 3'd7) begin
                  active <= 1'b0;
                  xdone  <= 1'b1;
               end else begin
                  bitn  <= bitn + 1'b1;
                  sh_tx <= {sh_tx[6:0], 1'b1};
               end
            end
         end
      end
   end

   assign mosi    = active ? sh_tx[7] : 1'b1;
   assign rx_byte = sh_rx;

endmodule

// File: rtl/sdspi_frame_build.sv
module sdspi_frame_build
   import sdspi_cmd_pkg::*;
#(
   parameter logic [7:0] CRC_BYTE = 8'h95
) (
   input  logic [5:0]             idx,
   input  logic [8*ARG_BYTES-1:0] arg,
   input  logic [FIDX_W-1:0]      sel,
   output logic [7:0]             byte_o
);

   logic [7:0] fr [FRAME_BYTES];

   assign fr[0] = {START_PREFIX, idx};

   genvar g;
   generate
      for (g = 0; g < ARG_BYTES; g++) begin : g_arg
         assign fr[g+1] = arg[8*(ARG_BYTES-g)-1 -: 8];
      end
   endgenerate

   assign fr[FRAME_BYTES-1] = CRC_BYTE;

   always_comb begin
      byte_o = IDLE_BYTE;
      for (int k = 0; k < FRAME_BYTES; k++) begin
         if (sel == FIDX_W'(k)) byte_o = fr[k];
      end
   end

endmodule

// File: rtl/sdspi_wait_timer.sv
module sdspi_wait_timer #(
   parameter int unsigned LIMIT = 5_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired
);

   localparam int W = $clog2(LIMIT + 1);

   logic [W-1:0] cnt;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (cnt != W'(LIMIT)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign expired = (cnt == W'(LIMIT));

endmodule

// File: rtl/sdspi_cmd_framer.sv
module sdspi_cmd_framer
   import sdspi_cmd_pkg::*;
#(
   parameter int          CLK_DIV           = 4,
   parameter int unsigned READY_WAIT_CYCLES = 5_000_000,
   parameter int          POLL_LIMIT        = 10,
   parameter int          OCR_BYTES         = 4,
   parameter logic [7:0]  CRC_BYTE          = 8'h95
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [5:0]             cmd_idx,
   input  logic [31:0]            cmd_arg,
   output logic                   busy,
   output logic                   done,
   output logic [7:0]             resp,
   output logic [8*OCR_BYTES-1:0] extra,
   output logic                   spi_sclk,
   output logic                   spi_mosi,
   input  logic                   spi_miso
);

   localparam int EXTRA_W = 8 * OCR_BYTES;
   localparam int POLL_W  = $clog2(POLL_LIMIT + 1);

   generate
      if (POLL_LIMIT < 1) begin : g_bad_poll
         $error("POLL_LIMIT must be at least 1");
      end
      if (OCR_BYTES < 2 || OCR_BYTES > 8) begin : g_bad_ocr
         $error("OCR_BYTES must lie in 2..8");
      end
   endgenerate

   fr_state_t          st;
   logic [5:0]         idx_q;
   logic [31:0]        arg_q;
   logic [FIDX_W-1:0]  fidx;
   logic [POLL_W-1:0]  pcnt;
   logic               inflight;
   logic               accept;
   logic               xfer_go;
   logic               xfer_done;
   logic [7:0]         xfer_tx;
   logic [7:0]         xfer_rx;
   logic [7:0]         frame_byte;
   logic               rdy_expired;
   logic               in_xfer_state;

   assign accept = (st == ST_IDLE) && start;

   always_comb begin
      case (st)
         ST_FLUSH, ST_READY, ST_SEND, ST_STUFF, ST_RESP, ST_OCR: in_xfer_state = 1'b1;
         default:                                                in_xfer_state = 1'b0;
      endcase
   end

   assign xfer_go = in_xfer_state && !inflight;
   assign xfer_tx = (st == ST_SEND) ? frame_byte : IDLE_BYTE;

   sdspi_frame_build #(
      .CRC_BYTE (CRC_BYTE)
   ) u_frame (
      .idx    (idx_q),
      .arg    (arg_q),
      .sel    (fidx),
      .byte_o (frame_byte)
   );

   sdspi_wait_timer #(
      .LIMIT (READY_WAIT_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .expired (rdy_expired)
   );

   sdspi_byte_xfer #(
      .CLK_DIV (CLK_DIV)
   ) u_xfer (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (xfer_go),
      .tx_byte (xfer_tx),
      .xdone   (xfer_done),
      .rx_byte (xfer_rx),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi),
      .miso    (spi_miso)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight <= 1'b0;
      end else if (xfer_go) begin
         inflight <= 1'b1;
      end else if (xfer_done) begin
         inflight <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         idx_q <= '0;
         arg_q <= '0;
         fidx  <= '0;
         pcnt  <= '0;
         resp  <= IDLE_BYTE;
         extra <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  idx_q <= cmd_idx;
                  arg_q <= cmd_arg;
                  extra <= '0;
                  st    <= ST_FLUSH;
               end
            end
            ST_FLUSH: begin
               if (xfer_done) st <= ST_READY;
            end
            ST_READY: begin
               if (xfer_done) begin
                  if (xfer_rx == IDLE_BYTE) begin
                     fidx <= '0;
                     st   <= ST_SEND;
                  end else if (rdy_expired) begin
                     resp <= IDLE_BYTE;
                     st   <= ST_FIN;
                  end
               end
            end
            ST_SEND: begin
               if (xfer_done) begin
                  if (fidx == FIDX_W'(FRAME_BYTES - 1)) begin
                     pcnt <= '0;
                     st   <= (idx_q == IDX_STOP) ? ST_STUFF : ST_RESP;
                  end else begin
                     fidx <= fidx + 1'b1;
                  end
               end
            end
            ST_STUFF: begin
               if (xfer_done) st <= ST_RESP;
            end
            ST_RESP: begin
               if (xfer_done) begin
                  resp <= xfer_rx;
                  pcnt <= pcnt + 1'b1;
                  if (!xfer_rx[7] || (pcnt == POLL_W'(POLL_LIMIT - 1))) begin
                     if ((idx_q == IDX_READ_OCR) && (xfer_rx == 8'h00)) begin
                        fidx <= '0;
                        st   <= ST_OCR;
                     end else begin
                        st <= ST_FIN;
                     end
                  end
               end
            end
            ST_OCR: begin
               if (xfer_done) begin
                  extra <= {extra[EXTRA_W-9:0], xfer_rx};
                  if (fidx == FIDX_W'(OCR_BYTES - 1)) begin
                     st <= ST_FIN;
                  end else begin
                     fidx <= fidx + 1'b1;
                  end
               end
            end
            ST_FIN: begin
               st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);
   assign done = (st == ST_FIN);

endmodule

// File: rtl/sdspi_cmd_framer_chk.sv
module sdspi_cmd_framer_chk #(
   parameter int EXTRA_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic [7:0]         resp,
   input logic [EXTRA_W-1:0] extra,
   input logic               spi_sclk,
   input logic               spi_mosi
);

   assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   assert_busy_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   assert_line_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!spi_sclk && spi_mosi));

   assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> ($stable(resp) && $stable(extra)));

endmodule

bind sdspi_cmd_framer sdspi_cmd_framer_chk #(
   .EXTRA_W (8 * OCR_BYTES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .resp     (resp),
   .extra    (extra),
   .spi_sclk (spi_sclk),
   .spi_mosi (spi_mosi)
);

// File: tb/tb_sdspi_cmd_framer.sv
module tb_sdspi_cmd_framer;

   localparam int CLK_PERIOD = 10;
   localparam int NV         = 6;
   localparam int MEMN       = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  cmd_idx = '0;
   logic [31:0] cmd_arg = '0;
   logic        busy, done;
   logic [7:0]  resp;
   logic [31:0] extra;
   logic        spi_sclk, spi_mosi;
   logic        spi_miso;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdspi_cmd_framer #(
      .CLK_DIV           (2),
      .READY_WAIT_CYCLES (400),
      .POLL_LIMIT        (10),
      .OCR_BYTES         (4),
      .CRC_BYTE          (8'h95)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cmd_idx  (cmd_idx),
      .cmd_arg  (cmd_arg),
      .busy     (busy),
      .done     (done),
      .resp     (resp),
      .extra    (extra),
      .spi_sclk (spi_sclk),
      .spi_mosi (spi_mosi),
      .spi_miso (spi_miso)
   );

   // card model: reply bytes scripted by the bench, outgoing bytes logged
   logic [7:0] reply_mem [MEMN];
   logic [7:0] fill_byte = 8'hFF;
   logic [7:0] mosi_log [128];
   int         log_n = 0;
   logic       model_clr = 1'b0;

   initial begin
      int         ptr;
      int         bitc;
      logic [7:0] cur;
      logic [7:0] sh;
      ptr = 0; bitc = 0; cur = 8'hFF; sh = 8'h00;
      spi_miso = 1'b1;
      forever begin
         @(posedge spi_sclk or posedge model_clr);
         if (model_clr) begin
            ptr = 0; bitc = 0; log_n = 0;
            cur = reply_mem[0];
         end else begin
            sh = {sh[6:0], spi_mosi};
            bitc++;
            if (bitc == 8) begin
               if (log_n < 128) mosi_log[log_n] = sh;
               log_n++;
               bitc = 0;
               ptr++;
               cur = (ptr < MEMN) ? reply_mem[ptr] : fill_byte;
            end
         end
         spi_miso = cur[7 - bitc];
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load_script(input int busy_n, input bit stuff, input int lead,
                              input logic [7:0] rbyte, input logic [31:0] ocr);
      int k;
      for (int i = 0; i < MEMN; i++) reply_mem[i] = 8'hFF;
      fill_byte = 8'hFF;
      k = 0;
      reply_mem[k] = 8'h00; k++;
      for (int i = 0; i < busy_n; i++) begin reply_mem[k] = 8'h00; k++; end
      reply_mem[k] = 8'hFF; k++;
      k += 6;
      if (stuff) begin reply_mem[k] = 8'h00; k++; end
      k += lead;
      if (k < MEMN) reply_mem[k] = rbyte;
      k++;
      for (int i = 0; i < 4; i++) begin
         if (k < MEMN) reply_mem[k] = ocr[31 - 8*i -: 8];
         k++;
      end
   endtask

   task automatic model_reset();
      model_clr = 1'b1;
      #1;
      model_clr = 1'b0;
   endtask

   task automatic pulse_start(input logic [5:0] idx, input logic [31:0] arg);
      @(negedge clk);
      cmd_idx = idx;
      cmd_arg = arg;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      check(busy == 1'b1, "R9 busy one cycle after start", 32'(busy), 32'd1);
   endtask

   task automatic wait_done(input bit poke, output bit seen);
      int n;
      n = 0;
      seen = 1'b0;
      while (!done && n < 20000) begin
         if (poke && n == 40) begin
            cmd_idx = 6'd9;
            cmd_arg = 32'hDEADBEEF;
            start   = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      seen = done;
   endtask

   task automatic run_vec(input logic [5:0] idx, input logic [31:0] arg, input int busy_n,
                          input int lead, input logic [7:0] rbyte, input logic [31:0] ocr,
                          input bit poke);
      bit          stuff, seen, ocr_rd;
      int          npoll, exp_n, fo, dcnt;
      logic [7:0]  exp_r;
      logic [31:0] exp_x;
      logic [7:0]  efr [6];
      stuff  = (idx == 6'd12);
      npoll  = (lead >= 10) ? 10 : lead + 1;
      exp_r  = (lead >= 10) ? 8'hFF : rbyte;
      ocr_rd = (idx == 6'd58) && (exp_r == 8'h00);
      exp_x  = ocr_rd ? ocr : 32'h0;
      exp_n  = 2 + busy_n + 6 + (stuff ? 1 : 0) + npoll + (ocr_rd ? 4 : 0);
      load_script(busy_n, stuff, lead, rbyte, ocr);
      model_reset();
      pulse_start(idx, arg);
      wait_done(poke, seen);
      check(seen, "R9 done reached", 32'(seen), 32'd1);
      check(resp == exp_r, "R7 reply byte", 32'(resp), 32'(exp_r));
      check(extra == exp_x, "R8 extra field", extra, exp_x);
      @(negedge clk);
      check(!busy && !done, "R9 release after done", {30'd0, busy, done}, 32'd0);
      check(log_n == exp_n, "R4 R6 R7 byte count", 32'(log_n), 32'(exp_n));
      efr[0] = {2'b01, idx};
      efr[1] = arg[31:24]; efr[2] = arg[23:16]; efr[3] = arg[15:8]; efr[4] = arg[7:0];
      efr[5] = 8'h95;
      fo = busy_n + 2;
      check(mosi_log[fo] == efr[0], "R1 first frame byte", 32'(mosi_log[fo]), 32'(efr[0]));
      for (int i = 1; i < 5; i++)
         check(mosi_log[fo+i] == efr[i], "R2 argument byte", 32'(mosi_log[fo+i]), 32'(efr[i]));
      check(mosi_log[fo+5] == 8'h95, "R3 crc byte", 32'(mosi_log[fo+5]), 32'h95);
      for (int i = 0; i < log_n && i < 128; i++) begin
         if (i < fo || i > fo + 5)
            check(mosi_log[i] == 8'hFF, "R11 idle byte out", 32'(mosi_log[i]), 32'hFF);
      end
      dcnt = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (done) dcnt++;
      end
      check(dcnt == 0, "R10 R9 single done", 32'(dcnt), 32'd0);
      check(resp == exp_r && extra == exp_x, "R12 results held", 32'(resp), 32'(exp_r));
   endtask

   // stimulus table: index, argument, busy bytes, leading FF bytes, reply, trailing word
   localparam logic [5:0]  V_IDX  [NV] = '{6'd0, 6'd17, 6'd58, 6'd12, 6'd24, 6'd58};
   localparam logic [31:0] V_ARG  [NV] = '{32'h0, 32'h12345678, 32'h0, 32'h0, 32'hA5A50001, 32'h40000000};
   localparam int          V_BUSY [NV] = '{0, 3, 1, 0, 0, 2};
   localparam int          V_LEAD [NV] = '{1, 0, 2, 0, 12, 1};
   localparam logic [7:0]  V_RESP [NV] = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05};
   localparam logic [31:0] V_OCR  [NV] = '{32'h0, 32'h0, 32'hC0FF8000, 32'h0, 32'h0, 32'hABCD1234};

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit seen;
      for (int i = 0; i < MEMN; i++) reply_mem[i] = 8'hFF;
      repeat (3) @(negedge clk);
      check(!busy && !done, "R9 reset idle", {30'd0, busy, done}, 32'd0);
      check(resp == 8'hFF && extra == 32'h0, "R12 reset results", 32'(resp), 32'hFF);
      check(!spi_sclk && spi_mosi, "R11 reset line levels", {30'd0, spi_sclk, spi_mosi}, 32'd1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++)
         run_vec(V_IDX[v], V_ARG[v], V_BUSY[v], V_LEAD[v], V_RESP[v], V_OCR[v], 1'b0);

      // start while busy: second request must not disturb the first
      run_vec(6'd17, 32'h00000200, 1, 0, 8'h00, 32'h0, 1'b1);

      // ready timeout: card never returns FF
      for (int i = 0; i < MEMN; i++) reply_mem[i] = 8'h00;
      fill_byte = 8'h00;
      model_reset();
      pulse_start(6'd17, 32'h11223344);
      wait_done(1'b0, seen);
      check(seen, "R5 done after timeout", 32'(seen), 32'd1);
      check(resp == 8'hFF, "R5 timeout reply", 32'(resp), 32'hFF);
      check(extra == 32'h0, "R5 timeout extra", extra, 32'h0);
      check(log_n >= 2, "R5 bytes clocked while waiting", 32'(log_n), 32'd2);
      for (int i = 0; i < log_n && i < 128; i++)
         check(mosi_log[i] == 8'hFF, "R5 no frame sent", 32'(mosi_log[i]), 32'hFF);
      repeat (4) @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule